// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block keeps a 63-bit tick count that advances by one on every cycle where its tick enable is high. Next to the count it holds a compare value. When the count reaches the compare value and the compare is armed, the block pulses one soft-interrupt bit and a wake line for a single cycle. The most significant bit of each 64-bit register is a control flag and takes no part in the arithmetic. On the count register, that bit is a trap flag for non-privileged reads. On the compare register, it is an interrupt disable.

Software writes either register through a shared write data bus, with one write strobe per register. Both registers can be read at all times on their own read buses. A compare value of zero leaves the compare unarmed, and so does a set disable flag. A compare value written at or below the count it is about to hold is treated as already passed, and it fires on the very next tick, so the event is never lost. Each write to the compare register arms it for one event only. A parameter chooses which soft-interrupt bit is raised, so the same block serves as the primary tick or as the system tick.

Top module: `tick_compare`

## Requirements
- R1: After reset the count reads 0 with the trap flag (bit 63) at 1, the compare reads 0 with the disable flag (bit 63) at 1, and `wake` and `sint_set` are 0.
- R2: A count write loads `wdata[62:0]` as the count and `wdata[63]` as the trap flag. The write takes priority over a tick in the same cycle.
- R3: `cnt_rdata[63]` always equals the stored trap flag, and `cnt_rdata[62:0]` equals the count.
- R4: A tick cycle with no count write raises the count by one, wrapping from 2^63-1 to 0. Bit 63 does not change.
- R5: A compare write stores `wdata[62:0]` as the compare value and `wdata[63]` as the disable flag, and both read back on `lim_rdata`.
- R6: When an armed compare sees a tick that brings the count equal to the compare value, `wake` goes high for one cycle. The edge that raises it is the same edge at which the count reads the compare value. A compare-write cycle never fires.
- R7: A compare value of zero never produces an interrupt, even when the count passes zero.
- R8: With the disable flag set, no interrupt is produced, even when the count passes the compare value.
- R9: A compare write whose value is less than or equal to the count held after that cycle fires on the next tick.
- R10: Each compare write arms at most one event. After it fires, no further pulse comes until the compare is written again, and a new compare write replaces any pending event.
- R11: On a fire, `sint_set` has exactly bit `SINT_BIT` set (for example 16 for a system-tick instance) and is 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the count this cycle |
| cnt_we | input | 1 | Write `wdata` to the count register |
| lim_we | input | 1 | Write `wdata` to the compare register |
| wdata | input | DW | Shared write data |
| cnt_rdata | output | DW | Trap flag and count |
| lim_rdata | output | DW | Disable flag and compare value |
| sint_set | output | SINT_W | One-cycle soft-interrupt set pulse |
| wake | output | 1 | One-cycle core wake pulse |

## Verification
The arming state and the pending flag for an already-passed compare cannot be seen on any read bus. A fault in either shows up only as a `wake` pulse that is missing, extra or late, on the tick cycle where the count reaches the compare, or on the first tick after a late compare write. Errors in the flags or the count show up on the read buses one cycle after the write or tick that caused them. The bench therefore keeps its own model and compares every output after every cycle. Its random stimulus uses small value ranges so that matches, late writes and disabled compares occur many times.

// File: rtl/tick_compare.sv
module tick_compare #(
  parameter int DW       = 64,
  parameter int SINT_W   = 32,
  parameter int SINT_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cnt_we,
  input  logic              lim_we,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     cnt_rdata,
  output logic [DW-1:0]     lim_rdata,
  output logic [SINT_W-1:0] sint_set,
  output logic              wake
);
  localparam int VW = DW - 1;
  localparam logic [SINT_W-1:0] SINT_MASK = {{(SINT_W-1){1'b0}}, 1'b1} << SINT_BIT;

  logic [VW-1:0] count_q, limit_q, count_nx, wval;
  logic npt_q, dis_q, armed_q, late_q;
  logic adv, fire;

  assign wval     = wdata[VW-1:0];
  assign adv      = tick_en & ~cnt_we;
  assign count_nx = cnt_we ? wval : (adv ? count_q + 1'b1 : count_q);
  assign fire     = armed_q & adv & ~lim_we & (late_q | (count_nx == limit_q));

  assign cnt_rdata = {npt_q, count_q};
  assign lim_rdata = {dis_q, limit_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q  <= '0;
      npt_q    <= 1'b1;
      limit_q  <= '0;
      dis_q    <= 1'b1;
      armed_q  <= 1'b0;
      late_q   <= 1'b0;
      sint_set <= '0;
      wake     <= 1'b0;
    end else begin
      count_q <= count_nx;
      if (cnt_we) npt_q <= wdata[DW-1];
      if (lim_we) begin
        limit_q <= wval;
        dis_q   <= wdata[DW-1];
        armed_q <= ~wdata[DW-1] & (|wval);
        late_q  <= wval <= count_nx;
      end else if (fire) begin
        armed_q <= 1'b0;
        late_q  <= 1'b0;
      end
      sint_set <= fire ? SINT_MASK : '0;
      wake     <= fire;
    end
  end
endmodule

// File: rtl/tick_compare_chk.sv
module tick_compare_chk #(
  parameter int DW       = 64,
  parameter int SINT_W   = 32,
  parameter int SINT_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              cnt_we,
  input logic              lim_we,
  input logic [DW-1:0]     wdata,
  input logic [DW-1:0]     cnt_rdata,
  input logic [DW-1:0]     lim_rdata,
  input logic [SINT_W-1:0] sint_set,
  input logic              wake
);
  localparam int VW = DW - 1;

  p_cnt_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cnt_we)) |-> cnt_rdata == $past(wdata));

  p_tick_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(tick_en) && !$past(cnt_we)) |->
      (cnt_rdata[VW-1:0] == VW'($past(cnt_rdata[VW-1:0]) + 1'b1) &&
       cnt_rdata[DW-1] == $past(cnt_rdata[DW-1])));

  p_lim_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(lim_we)) |-> lim_rdata == $past(wdata));

  p_no_fire_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !$past(lim_we));

  p_zero_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> lim_rdata[VW-1:0] != '0);

  p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !lim_rdata[DW-1]);

  p_one_shot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  p_sint_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sint_set) && (sint_set[SINT_BIT] == wake) && ($countones(sint_set) == 32'(wake)));
endmodule

bind tick_compare tick_compare_chk #(.DW(DW), .SINT_W(SINT_W), .SINT_BIT(SINT_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_we(cnt_we), .lim_we(lim_we),
  .wdata(wdata), .cnt_rdata(cnt_rdata), .lim_rdata(lim_rdata),
  .sint_set(sint_set), .wake(wake)
);

// File: tb/tick_compare_bench.sv
module tick_compare_bench;
  localparam int DW = 64, SW = 32, SB = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_en = 1'b0, cnt_we = 1'b0, lim_we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] cnt_rdata, lim_rdata;
  logic [SW-1:0] sint_set;
  logic wake;

  int checks = 0, fails = 0;

  logic [62:0] m_cnt, m_lim;
  logic m_npt, m_dis, m_arm, m_late, m_wake;

  always #10 clk = ~clk;

  tick_compare #(.DW(DW), .SINT_W(SW), .SINT_BIT(SB)) u_tick_compare (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_we(cnt_we), .lim_we(lim_we),
    .wdata(wdata), .cnt_rdata(cnt_rdata), .lim_rdata(lim_rdata),
    .sint_set(sint_set), .wake(wake)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] exp_sint(input logic f);
    return f ? (SW'(1) << SB) : '0;
  endfunction

  task automatic step(input bit t, input bit cw, input bit lw, input logic [63:0] d);
    logic [62:0] nx;
    logic adv, fire;
    @(negedge clk);
    tick_en = t; cnt_we = cw; lim_we = lw; wdata = d;
    adv  = t && !cw;
    nx   = cw ? d[62:0] : (adv ? m_cnt + 63'd1 : m_cnt);
    fire = m_arm && adv && !lw && (m_late || nx == m_lim);
    m_cnt = nx;
    if (cw) m_npt = d[63];
    if (lw) begin
      m_lim = d[62:0]; m_dis = d[63];
      m_arm = !d[63] && (d[62:0] != 0);
      m_late = d[62:0] <= nx;
    end else if (fire) begin
      m_arm = 0; m_late = 0;
    end
    m_wake = fire;
    @(posedge clk); #1;
    chk(cnt_rdata == {m_npt, m_cnt}, cw ? "R2 count write" : "R3/R4 count read", cnt_rdata, {m_npt, m_cnt});
    chk(lim_rdata == {m_dis, m_lim}, "R5 compare read", lim_rdata, {m_dis, m_lim});
    chk(wake == m_wake, "R6 wake", 64'(wake), 64'(m_wake));
    chk(sint_set == exp_sint(m_wake), "R11 sint bit", 64'(sint_set), 64'(exp_sint(m_wake)));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, '0);
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    m_cnt = 0; m_npt = 1; m_lim = 0; m_dis = 1; m_arm = 0; m_late = 0; m_wake = 0;
    #1;
    chk(cnt_rdata == 64'h8000_0000_0000_0000, "R1 reset count", cnt_rdata, 64'h8000_0000_0000_0000);
    chk(lim_rdata == 64'h8000_0000_0000_0000, "R1 reset compare", lim_rdata, 64'h8000_0000_0000_0000);
    chk(!wake && sint_set == 0, "R1 reset pulses", 64'(sint_set), 0);

    // R8: disabled after reset, ticking past 0 gives nothing
    ticks(3);
    chk(!wake, "R8 reset-disabled", 64'(wake), 0);

    // R2: write beats tick; R3 trap flag readback
    step(1, 1, 0, 64'h8000_0000_0000_0064);
    chk(cnt_rdata == 64'h8000_0000_0000_0064, "R2 write over tick", cnt_rdata, 64'h8000_0000_0000_0064);
    step(0, 1, 0, 64'd100);
    chk(cnt_rdata[63] == 1'b0, "R3 trap flag clear", cnt_rdata, 64'd100);

    // R6: match at 105
    step(0, 0, 1, 64'd105);
    ticks(4);
    chk(!wake, "R6 not before match", 64'(wake), 0);
    step(1, 0, 0, '0);
    chk(wake && cnt_rdata[62:0] == 63'd105, "R6 match fire", cnt_rdata, 64'd105);
    // R10: one shot
    ticks(5);
    step(1, 1, 0, 64'd104);
    step(1, 0, 0, '0);
    chk(!wake, "R10 no refire", 64'(wake), 0);

    // R9: late compare
    step(0, 1, 0, 64'd200);
    step(0, 0, 1, 64'd50);
    chk(!wake, "R9 not on write", 64'(wake), 0);
    step(1, 0, 0, '0);
    chk(wake, "R9 late fire", 64'(wake), 1);
    // R9: equal compare counts as passed
    step(0, 0, 1, 64'd201);
    step(1, 0, 0, '0);
    chk(wake, "R9 equal fire", 64'(wake), 1);

    // R8: disable flag with reachable value
    step(0, 0, 1, 64'h8000_0000_0000_00CC);
    ticks(3);
    chk(!wake, "R8 disabled match", 64'(wake), 0);

    // R4 wrap and R7 zero compare
    step(0, 1, 0, 64'h7FFF_FFFF_FFFF_FFFE);
    step(0, 0, 1, 64'd0);
    ticks(3);
    chk(cnt_rdata == 64'd1 && !wake, "R4/R7 wrap, zero compare", cnt_rdata, 64'd1);

    // R10: rewrite replaces pending event
    step(0, 1, 0, 64'd10);
    step(0, 0, 1, 64'd12);
    step(0, 0, 1, 64'd20);
    ticks(2);
    chk(!wake, "R10 replaced compare", 64'(wake), 0);
    ticks(8);
    chk(wake, "R10 new compare fires", 64'(wake), 1);

    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [63:0] d;
      r = $urandom_range(0, 99);
      d = {($urandom_range(0, 3) == 0), 55'd0, 8'($urandom_range(0, 255))};
      if (r < 6)       step($urandom_range(0, 1), 1, 0, d);
      else if (r < 14) step($urandom_range(0, 1), 0, 1, d);
      else if (r < 16) step(1, 1, 1, d);
      else             step($urandom_range(0, 3) != 0, 0, 0, '0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule